// File: doc/BRIEF.md
# Key-Refreshed External Watchdog Monitor

This block watches software from outside the processor. It sits on a small 8-bit register bus with two locations. The first is a control register that holds an enable bit, a fault-input polarity bit and a fault-input enable bit. The second is a write-only service location. Once the monitor is enabled, a counter advances on every clock. Software keeps the fault output low by writing the two-byte key, 0xB4 and then 0x2C, to the service location. If the counter runs out, or the key is wrong, or the second byte comes too late, the fault output is raised. The fault output then stays high until a correct key sequence completes.

An external fault pin can also drive the fault output. The pin first passes through a synchroniser. It counts only while its enable bit is set, and its active level is chosen by the polarity bit. The enable bit is write-once. The first control write after reset may set it or clear it. Later writes can only clear it, and once it is clear the monitor stays off until the next reset.

The key checker is a three-state machine:
- KEY_OFF: the monitor is disabled.
- KEY_IDLE: the checker waits for the first byte.
- KEY_ARMED: 0xB4 has been accepted and the window for the second byte is open.

Its transitions are:
- ARM: a 0xB4 write in OFF with the monitor enabled, or in IDLE.
- ACCEPT: a 0x2C write in ARMED, which returns to IDLE.
- REJECT: a wrong byte in ARMED, which returns to IDLE.
- EXPIRE: the window ends in ARMED with no write, which returns to IDLE.
- DISABLE: any state goes to OFF when the enable bit is clear.

Top module: `ext_wdog_monitor`

## Requirements
- R1: Address 0 reads as the control register. Bit 0 is enable, bit 1 is fault-input polarity and bit 2 is fault-input enable. Bits 7..3 read 0 and all bits reset to 0. Address 1, the service location, always reads 0x00.
- R2: The first control write after reset loads the enable bit freely. Every later write can only clear it. Once it is clear, it stays clear until reset.
- R3: While enable is 0, fault_out is 0 and service writes have no effect. A 0xB4 written while disabled does not arm the checker.
- R4: If enabled with no refresh, fault_out rises after the clock edge that lies TIMEOUT_CYC edges after the enabling write or the last valid refresh.
- R5: A write of 0xB4 followed by 0x2C to the service location is a valid refresh. It clears the counter and drops a latched fault.
- R6: Any service write other than 0xB4 while no key is in progress latches a fault.
- R7: A second byte other than 0x2C latches a fault, and the checker returns to waiting for a first byte.
- R8: 0x2C is accepted on any of the SERV_TIME edges that follow the 0xB4 edge. If no write arrives by then, a fault is latched.
- R9: A latched fault stays asserted until a valid refresh, even when other service writes occur.
- R10: ext_fault_in passes through SYNC_STAGES flip-flops. With input-enable set, it forces fault_out high while its level equals the polarity bit (0 is active-low, 1 is active-high). With input-enable clear, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 1 | Write address: 0 control, 1 service |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 service |
| rd_data | output | 8 | Combinational read data |
| ext_fault_in | input | 1 | Asynchronous external fault pin |
| fault_out | output | 1 | Watchdog fault output, active high |

## Verification
The key checker is driven with several patterns:
- A correct pair.
- A wrong first byte.
- A correct first byte followed by a wrong second byte.
- A second byte on the last cycle of the window.
- A second byte one cycle past the window.

Together these separate an accepted key from each way of rejecting one, and the two window cases pin down the window length exactly. The timeout is checked one cycle before and at the expiry edge. The external pin is driven with both polarities and with its enable on and off, which tells the synchroniser latency apart from polarity errors. A mid-run reset shows that the write-once lock is released only by reset.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    localparam int DATA_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_SERV = 1'b1;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hB4;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h2C;

    localparam int CTL_EN   = 0;
    localparam int CTL_POL  = 1;
    localparam int CTL_INEN = 2;

    typedef enum logic [1:0] {
        KEY_OFF   = 2'd0,
        KEY_IDLE  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic inen;
        logic pol;
        logic en;
    } ctl_t;
endpackage

// File: rtl/wdm_regs.sv
module wdm_regs
    import wdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctl_t              ctl,
    output logic              serv_wr,
    output logic [DATA_W-1:0] serv_data
);
    logic ctl_wr;
    logic en_lock;

    assign ctl_wr    = wr_en && (wr_addr == ADDR_CTRL);
    assign serv_wr   = wr_en && (wr_addr == ADDR_SERV);
    assign serv_data = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl     <= '0;
            en_lock <= 1'b0;
        end else if (ctl_wr) begin
            ctl.pol  <= wr_data[CTL_POL];
            ctl.inen <= wr_data[CTL_INEN];
            ctl.en   <= en_lock ? (ctl.en & wr_data[CTL_EN]) : wr_data[CTL_EN];
            en_lock  <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data[CTL_EN]   = ctl.en;
            rd_data[CTL_POL]  = ctl.pol;
            rd_data[CTL_INEN] = ctl.inen;
        end
    end

    // R2
    en_no_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lock && !ctl.en) |=> !ctl.en);

    // R1
    serv_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_SERV) |-> (rd_data == '0));
endmodule

// File: rtl/wdm_keyseq.sv
module wdm_keyseq
    import wdm_pkg::*;
#(
    parameter int SERV_TIME = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              serv_wr,
    input  logic [DATA_W-1:0] serv_data,
    output logic              key_ok,
    output logic              key_bad
);
    localparam int WIN_W = (SERV_TIME > 1) ? $clog2(SERV_TIME) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SERV_TIME - 1);

    key_state_e       state, nxt;
    logic [WIN_W-1:0] win_cnt;
    logic             win_last;
    logic             is_first, is_second;

    assign win_last  = (win_cnt == WIN_LAST);
    assign is_first  = (serv_data == KEY_FIRST);
    assign is_second = (serv_data == KEY_SECOND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= KEY_OFF;
            win_cnt <= '0;
        end else begin
            state   <= nxt;
            win_cnt <= (state == KEY_ARMED && nxt == KEY_ARMED) ? win_cnt + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            KEY_OFF, KEY_IDLE: begin
                if (!en)                     nxt = KEY_OFF;
                else if (serv_wr && is_first) nxt = KEY_ARMED;
                else                         nxt = KEY_IDLE;
            end
            KEY_ARMED: begin
                if (!en)                      nxt = KEY_OFF;
                else if (serv_wr || win_last) nxt = KEY_IDLE;
            end
            default: nxt = KEY_OFF;
        endcase
    end

    // outputs
    always_comb begin
        key_ok  = 1'b0;
        key_bad = 1'b0;
        unique case (state)
            KEY_OFF, KEY_IDLE: begin
                key_bad = en && serv_wr && !is_first;
            end
            KEY_ARMED: begin
                key_ok  = en && serv_wr && is_second;
                key_bad = en && ((serv_wr && !is_second) || (!serv_wr && win_last));
            end
            default: ;
        endcase
    end

    // R8
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_ARMED) |-> (win_cnt <= WIN_LAST));

    // R7
    bad_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> (state != KEY_ARMED));

    // R5
    ok_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> (state == KEY_IDLE));
endmodule

// File: rtl/wdm_wdcount.sv
module wdm_wdcount #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic key_ok,
    input  logic key_bad,
    output logic fault_lat
);
    localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             expired;

    assign expired = (cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            fault_lat <= 1'b0;
        end else if (!en) begin
            cnt       <= '0;
            fault_lat <= 1'b0;
        end else if (key_ok) begin
            cnt       <= '0;
            fault_lat <= 1'b0;
        end else begin
            if (key_bad || expired) fault_lat <= 1'b1;
            if (!expired)           cnt <= cnt + 1'b1;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fault_lat && !key_ok) |=> fault_lat);

    // R3
    en_rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (cnt == '0 && !fault_lat));
endmodule

// File: rtl/wdm_sync.sv
module wdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ext_wdog_monitor.sv
module ext_wdog_monitor
    import wdm_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024,
    parameter int SERV_TIME   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    input  logic       ext_fault_in,
    output logic       fault_out
);
    ctl_t              ctl;
    logic              serv_wr;
    logic [DATA_W-1:0] serv_data;
    logic              key_ok, key_bad;
    logic              fault_lat;
    logic              ext_s;
    logic              ext_active;

    wdm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ctl       (ctl),
        .serv_wr   (serv_wr),
        .serv_data (serv_data)
    );

    wdm_keyseq #(.SERV_TIME(SERV_TIME)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl.en),
        .serv_wr   (serv_wr),
        .serv_data (serv_data),
        .key_ok    (key_ok),
        .key_bad   (key_bad)
    );

    wdm_wdcount #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl.en),
        .key_ok    (key_ok),
        .key_bad   (key_bad),
        .fault_lat (fault_lat)
    );

    wdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_fault_in),
        .q     (ext_s)
    );

    assign ext_active = ctl.inen && (ext_s == ctl.pol);
    assign fault_out  = ctl.en && (fault_lat || ext_active);

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.en) |-> !fault_out);
endmodule

// File: tb/tb_ext_wdog_monitor.sv
module tb_ext_wdog_monitor;
    localparam int T  = 32;
    localparam int SV = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       ext_fault_in = 1'b1;
    logic       fault_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string      tag;
        logic       exp_fault;
        logic [7:0] exp_rd;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    ext_wdog_monitor #(.TIMEOUT_CYC(T), .SERV_TIME(SV), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_fault_in(ext_fault_in), .fault_out(fault_out)
    );

    // monitor: pop and compare at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (fault_out !== it.exp_fault || rd_data !== it.exp_rd) begin
                n_fail++;
                $display("FAIL %s: fault_out=%0b rd_data=%02h expected fault_out=%0b rd_data=%02h",
                         it.tag, fault_out, rd_data, it.exp_fault, it.exp_rd);
            end
        end
    end

    task automatic bus_write(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic expect_out(input string tag, input logic a,
                              input logic f, input logic [7:0] r);
        item_t it;
        rd_addr = a;
        it.tag = tag; it.exp_fault = f; it.exp_rd = r;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic refresh();
        bus_write(1'b1, 8'hB4);
        bus_write(1'b1, 8'h2C);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset values
        expect_out("R1 ctrl reset", 1'b0, 1'b0, 8'h00);
        expect_out("R1 serv reads zero", 1'b1, 1'b0, 8'h00);
        // R3 service writes ignored while disabled
        bus_write(1'b1, 8'h00);
        expect_out("R3 bad byte while disabled", 1'b0, 1'b0, 8'h00);
        bus_write(1'b1, 8'hB4);
        // enable with reserved bits set
        bus_write(1'b0, 8'hF9);
        expect_out("R1 reserved bits read zero", 1'b0, 1'b0, 8'h01);
        bus_write(1'b1, 8'h2C);
        expect_out("R3 B4 while disabled did not arm", 1'b0, 1'b1, 8'h01);
        refresh();
        expect_out("R5 refresh clears fault", 1'b0, 1'b0, 8'h01);
        // R4 timeout from refresh
        idle(T - 1);
        expect_out("R4 one cycle before timeout", 1'b0, 1'b0, 8'h01);
        idle(1);
        expect_out("R4 timeout fault", 1'b0, 1'b1, 8'h01);
        idle(5);
        expect_out("R9 fault held", 1'b0, 1'b1, 8'h01);
        bus_write(1'b1, 8'h11);
        expect_out("R9 fault held after stray write", 1'b0, 1'b1, 8'h01);
        refresh();
        expect_out("R5 refresh after timeout", 1'b0, 1'b0, 8'h01);
        // R6 wrong first byte
        bus_write(1'b1, 8'h55);
        expect_out("R6 wrong first byte", 1'b0, 1'b1, 8'h01);
        refresh();
        expect_out("R5 clear after R6", 1'b0, 1'b0, 8'h01);
        // R7 wrong second byte
        bus_write(1'b1, 8'hB4);
        bus_write(1'b1, 8'h2D);
        expect_out("R7 wrong second byte", 1'b0, 1'b1, 8'h01);
        refresh();
        expect_out("R7 checker back to idle", 1'b0, 1'b0, 8'h01);
        // R8 last accepted cycle
        bus_write(1'b1, 8'hB4);
        idle(SV - 1);
        bus_write(1'b1, 8'h2C);
        expect_out("R8 second byte at window end", 1'b0, 1'b0, 8'h01);
        // R8 late
        bus_write(1'b1, 8'hB4);
        idle(SV);
        expect_out("R8 window expired", 1'b0, 1'b1, 8'h01);
        bus_write(1'b1, 8'h2C);
        expect_out("R8 late second byte rejected", 1'b0, 1'b1, 8'h01);
        refresh();
        expect_out("R5 clear after R8", 1'b0, 1'b0, 8'h01);
        // R10 external input
        ext_fault_in = 1'b0;
        idle(4);
        expect_out("R10 input ignored while disabled", 1'b0, 1'b0, 8'h01);
        bus_write(1'b0, 8'h05);
        expect_out("R10 active-low input forces fault", 1'b0, 1'b1, 8'h05);
        ext_fault_in = 1'b1;
        idle(1);
        expect_out("R10 sync stage one", 1'b0, 1'b1, 8'h05);
        idle(1);
        expect_out("R10 released after two stages", 1'b0, 1'b0, 8'h05);
        bus_write(1'b0, 8'h07);
        expect_out("R10 active-high polarity", 1'b0, 1'b1, 8'h07);
        bus_write(1'b0, 8'h03);
        expect_out("R10 input enable cleared", 1'b0, 1'b0, 8'h03);
        // R2 write-once enable
        bus_write(1'b0, 8'h00);
        expect_out("R2 enable cleared", 1'b0, 1'b0, 8'h00);
        bus_write(1'b0, 8'h01);
        expect_out("R2 enable cannot be set again", 1'b0, 1'b0, 8'h00);
        idle(T + 4);
        expect_out("R3 no timeout while disabled", 1'b0, 1'b0, 8'h00);
        do_reset();
        bus_write(1'b0, 8'h01);
        expect_out("R2 enable after reset", 1'b0, 1'b0, 8'h01);
        idle(T - 1);
        expect_out("R4 before timeout from enable", 1'b0, 1'b0, 8'h01);
        idle(1);
        expect_out("R4 timeout from enable", 1'b0, 1'b1, 8'h01);
        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule